// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block is the digital register core of a serially programmed converter with a selectable output span. A 24-bit command frame is shifted in MSB-first while a chip-select/load line is held low. The frame fills a staging code register or a staging span register, and an update copies both staged values into the live registers that drive the converter. The live code (16 bits) and live span (4 bits) are the block's outputs. An update comes from a serial command or from a falling edge on a separate load-pulse input.

An asynchronous active-low clear zeroes only the live registers. The staged registers survive, so the next update brings back the previous output. A clear that arrives while a frame is open aborts that frame and raises a suspect flag for the staging registers. An active-low integrity flag goes low on power-up, on clear and during a supply dip, and stays low until an update executes. In strap mode the live span is taken from strap pins at each update, together with the code.

All serial, load and strap inputs are sampled on `clk`. Each level must be held for at least two `clk` cycles.

Top module: `dac_reg_core`

## Requirements
- R1: After `rst_n` is released, `dac_code` is 0, `dac_span` is 4'b0000 (unipolar 0 V to 5 V), `ok_n` is 0 and `buf_suspect` is 0.
- R2: A frame is bits [23:20] command, [19:16] ignored address and [15:0] data, shifted MSB-first on rising `sck`. Command 4'b0010 writes the staged code and 4'b0110 writes the staged span from data[3:0]. Command 4'b0011 updates, and 4'b0111 writes the staged code and then updates. Any other command changes nothing.
- R3: When `strap_mode` is 1, every update loads `strap_span` into `dac_span` in the same cycle as the code. The strap pins have no effect before that update.
- R4: While `clr_n` is low, `dac_code` and `dac_span` are 0. The staged registers keep their contents.
- R5: An update after a clear, whether serial or from the load pulse, restores the staged code and span to the outputs.
- R6: If `clr_n` is low while `cs_ld` is low, the open frame is not executed and `buf_suspect` goes to 1. The next executed staging write clears `buf_suspect`.
- R7: `ok_n` is 0 after reset, while `clr_n` is low, and in the cycle after `dip` is sampled high. It stays 0 after those conditions end.
- R8: `ok_n` goes to 1 only on an executed update.
- R9: A frame executes on the rising edge of `cs_ld`, and only if exactly 24 `sck` rising edges occurred while it was open. A frame with 23 or 25 bits changes nothing.
- R10: A falling edge on `ld_n` acts as an update only while `cs_ld` is high. During an open frame it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| clr_n | input | 1 | Clear of the live registers, active low, asynchronous |
| dip | input | 1 | Supply-dip indication, active high |
| cs_ld | input | 1 | Frame select; low opens a frame, rising edge executes it |
| sck | input | 1 | Serial bit clock, sampled on rising edge |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Load pulse, falling edge requests an update |
| strap_mode | input | 1 | 1 selects span from strap pins |
| strap_span | input | 4 | Strapped span value |
| dac_code | output | 16 | Live converter code |
| dac_span | output | 4 | Live span selection |
| ok_n | output | 1 | Integrity flag, low when data integrity is not assured |
| buf_suspect | output | 1 | Staged registers may hold a partial write |

## Verification
The bench sends frames that are one bit short and one bit long, and an unknown opcode. A design that counted bits loosely would execute these and change the code. It clears the outputs and then reloads them with the load pulse, which catches a clear that also wipes the staging registers, since the restored code would then be zero. It raises clear inside an open write-and-update frame and then closes that frame; a design without the abort would show the new code. It also pulses the load input mid-frame, cycles the supply-dip input across an update, and loads a strapped span different from the staged one. These expose a load pulse that is not gated, a flag that recovers on its own, and a span taken from the wrong source.

// File: rtl/dac_reg_core.sv
module dac_reg_core #(
  parameter int CODE_W = 16,
  parameter int SPAN_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              dip,
  input  logic              cs_ld,
  input  logic              sck,
  input  logic              sdi,
  input  logic              ld_n,
  input  logic              strap_mode,
  input  logic [SPAN_W-1:0] strap_span,
  output logic [CODE_W-1:0] dac_code,
  output logic [SPAN_W-1:0] dac_span,
  output logic              ok_n,
  output logic              buf_suspect
);
  localparam int OP_W    = 4;
  localparam int FRAME_W = OP_W + ADDR_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam logic [OP_W-1:0] OP_WR_CODE = 4'b0010;
  localparam logic [OP_W-1:0] OP_WR_SPAN = 4'b0110;
  localparam logic [OP_W-1:0] OP_UPDATE  = 4'b0011;
  localparam logic [OP_W-1:0] OP_WR_UPD  = 4'b0111;

  logic               sck_q, cs_q, ld_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   nbits;
  logic               aborted;
  logic [CODE_W-1:0]  in_code;
  logic [SPAN_W-1:0]  in_span;

  wire act_rst_n = rst_n & clr_n;
  wire cs_fall   = cs_q & ~cs_ld;
  wire cs_rise   = ~cs_q & cs_ld;
  wire sck_rise  = ~sck_q & sck & ~cs_ld;
  wire ld_fall   = ld_q & ~ld_n & cs_ld & cs_q;
  wire frame_ok  = cs_rise && nbits == CNT_W'(FRAME_W) && !aborted && clr_n;

  wire [OP_W-1:0]   op   = shreg[FRAME_W-1 -: OP_W];
  wire [CODE_W-1:0] data = shreg[CODE_W-1:0];

  wire do_wr_code = frame_ok && (op == OP_WR_CODE || op == OP_WR_UPD);
  wire do_wr_span = frame_ok && op == OP_WR_SPAN;
  wire upd        = (frame_ok && (op == OP_UPDATE || op == OP_WR_UPD)) || ld_fall;

  wire [CODE_W-1:0] next_code = (frame_ok && op == OP_WR_UPD) ? data : in_code;
  wire [SPAN_W-1:0] next_span = strap_mode ? strap_span : in_span;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      ld_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_ld;
      ld_q  <= ld_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      nbits   <= '0;
      aborted <= 1'b0;
    end else begin
      if (cs_fall) begin
        nbits   <= '0;
        aborted <= 1'b0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi};
        if (nbits != '1) nbits <= nbits + 1'b1;
      end
      if (!clr_n && !cs_q) aborted <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_code     <= '0;
      in_span     <= '0;
      buf_suspect <= 1'b0;
    end else begin
      if (do_wr_code) in_code <= data;
      if (do_wr_span) in_span <= data[SPAN_W-1:0];
      if (!clr_n && !cs_q)            buf_suspect <= 1'b1;
      else if (do_wr_code || do_wr_span) buf_suspect <= 1'b0;
    end

  always_ff @(posedge clk or negedge act_rst_n)
    if (!act_rst_n) begin
      dac_code <= '0;
      dac_span <= '0;
    end else if (upd) begin
      dac_code <= next_code;
      dac_span <= next_span;
    end

  always_ff @(posedge clk or negedge act_rst_n)
    if (!act_rst_n)  ok_n <= 1'b0;
    else if (dip)    ok_n <= 1'b0;
    else if (upd)    ok_n <= 1'b1;

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_code == '0 && dac_span == '0));

  assert_dip_drops_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dip |=> (!ok_n));

  assert_flag_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_n) |-> $past(upd));

  assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (!$past(upd) && $past(clr_n)) |-> $stable(dac_code));

  assert_strap_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && strap_mode && clr_n) |=> (!clr_n || dac_span == $past(strap_span)));

  assert_ld_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_ld && !frame_ok) |-> !upd);
endmodule

// File: tb/test_dac_reg_core.sv
module test_dac_reg_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr_n = 1'b1, dip = 1'b0;
  logic        cs_ld = 1'b1, sck = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic        strap_mode = 1'b0;
  logic [3:0]  strap_span = 4'h0;
  logic [15:0] dac_code;
  logic [3:0]  dac_span;
  logic        ok_n, buf_suspect;
  int          n_run = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dac_reg_core i_dac_reg_core (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dip(dip), .cs_ld(cs_ld),
    .sck(sck), .sdi(sdi), .ld_n(ld_n), .strap_mode(strap_mode),
    .strap_span(strap_span), .dac_code(dac_code), .dac_span(dac_span),
    .ok_n(ok_n), .buf_suspect(buf_suspect));

  // nbits, op, data, expected code, expected span, expected flag
  localparam int NV = 9;
  localparam logic [46:0] VEC [NV] = '{
    {6'd24, 4'h2, 16'h1234, 16'h0000, 4'h0, 1'b0},
    {6'd24, 4'h3, 16'h0000, 16'h1234, 4'h0, 1'b1},
    {6'd24, 4'h6, 16'h0003, 16'h1234, 4'h0, 1'b1},
    {6'd24, 4'h7, 16'hABCD, 16'hABCD, 4'h3, 1'b1},
    {6'd23, 4'h7, 16'h5555, 16'hABCD, 4'h3, 1'b1},
    {6'd25, 4'h7, 16'h5555, 16'hABCD, 4'h3, 1'b1},
    {6'd24, 4'h2, 16'h0F0F, 16'hABCD, 4'h3, 1'b1},
    {6'd24, 4'h3, 16'h0000, 16'h0F0F, 4'h3, 1'b1},
    {6'd24, 4'hF, 16'h1111, 16'h0F0F, 4'h3, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [23:0] w, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      sdi = (i < 24) ? w[23 - i] : 1'b0;
      sck = 1'b0; tick(2);
      sck = 1'b1; tick(2);
    end
    sck = 1'b0; tick(2);
  endtask

  task automatic frame(input logic [3:0] op, input logic [15:0] d, input int nb);
    cs_ld = 1'b0; tick(2);
    shift_bits({op, 4'h0, d}, 0, nb);
    cs_ld = 1'b1; tick(3);
  endtask

  task automatic ld_pulse();
    ld_n = 1'b0; tick(2);
    ld_n = 1'b1; tick(2);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1; tick(2);
    chk("R1 reset code", dac_code, 0);
    chk("R1 reset span", dac_span, 0);
    chk("R1 R7 reset flag", ok_n, 0);
    chk("R1 reset suspect", buf_suspect, 0);

    for (int v = 0; v < NV; v++) begin
      frame(VEC[v][40:37], VEC[v][36:21], int'(VEC[v][46:41]));
      chk($sformatf("R2 R9 vec%0d code", v), dac_code, VEC[v][20:5]);
      chk($sformatf("R2 R9 vec%0d span", v), dac_span, VEC[v][4:1]);
      chk($sformatf("R8 vec%0d flag", v), ok_n, VEC[v][0]);
    end

    clr_n = 1'b0; tick(2);
    chk("R4 clear code", dac_code, 0);
    chk("R4 clear span", dac_span, 0);
    chk("R7 clear flag", ok_n, 0);
    clr_n = 1'b1; tick(2);
    chk("R7 flag stays low", ok_n, 0);
    ld_pulse();
    chk("R5 restore code", dac_code, 16'h0F0F);
    chk("R5 restore span", dac_span, 4'h3);
    chk("R8 flag after load", ok_n, 1);

    cs_ld = 1'b0; tick(2);
    shift_bits({4'h7, 4'h0, 16'h7777}, 0, 10);
    clr_n = 1'b0; tick(2);
    clr_n = 1'b1; tick(2);
    shift_bits({4'h7, 4'h0, 16'h7777}, 10, 24);
    cs_ld = 1'b1; tick(3);
    chk("R6 aborted frame code", dac_code, 0);
    chk("R6 suspect set", buf_suspect, 1);
    chk("R8 no flag after abort", ok_n, 0);
    ld_pulse();
    chk("R5 R6 staged code kept", dac_code, 16'h0F0F);

    frame(4'h2, 16'h2222, 24);
    chk("R6 suspect cleared", buf_suspect, 0);
    cs_ld = 1'b0; tick(2);
    ld_pulse();
    cs_ld = 1'b1; tick(3);
    chk("R10 load ignored in frame", dac_code, 16'h0F0F);
    ld_pulse();
    chk("R10 load with cs high", dac_code, 16'h2222);

    dip = 1'b1; tick(2);
    chk("R7 dip flag", ok_n, 0);
    chk("R7 dip keeps code", dac_code, 16'h2222);
    dip = 1'b0; tick(2);
    chk("R7 flag held after dip", ok_n, 0);
    frame(4'h3, 16'h0000, 24);
    chk("R8 flag after update", ok_n, 1);

    strap_mode = 1'b1; strap_span = 4'hA;
    frame(4'h6, 16'h0005, 24);
    chk("R3 strap waits for update", dac_span, 4'h3);
    frame(4'h3, 16'h0000, 24);
    chk("R3 strap span loaded", dac_span, 4'hA);
    chk("R3 code with strap", dac_code, 16'h2222);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule